// File: doc/BRIEF.md
# Serial Buffer Write Front-End

This block is the receive side of a serial data buffer. It sits behind a three-wire serial port (serial clock, active-low select, serial data in) and turns a buffer-load command into a plain write port for one of two on-chip byte buffers. Each frame begins with an 8-bit command code that picks the target buffer. The code is followed by a 14-bit padding field whose content is ignored and a 10-bit start address. From then on, every group of eight serial bits becomes one byte, written to the current address. The address then moves on by one and returns to zero past the last byte of the 528-byte buffer.

The serial pins are brought into the system clock domain through synchroniser chains. Data is taken on each rising edge of the serial clock, so a host may use either idle polarity (SPI mode 0 or mode 3). Raising the select line ends the frame at any point. Any bits of an unfinished byte are thrown away, and the next frame starts again from a command code. A frame may stream any number of bytes.

Top module: `sbuf_wr_front`

## Requirements
- R1: Command code 0x84 (sent MSB first) writes to the first buffer (`wr_buf` = 0), and command code 0x87 writes to the second buffer (`wr_buf` = 1); `wr_buf` stays the same for every byte of a frame.
- R2: After the command code, 14 bits are skipped whatever their value, and the next 10 bits, MSB first, form the start address at which the first data byte is written.
- R3: Each later group of 8 bits, MSB first, is written as one byte with a single-cycle `wr_en` pulse carrying `wr_addr`, `wr_data` and `wr_buf`.
- R4: Each byte after the first goes to the next address, and the byte after address 527 goes to address 0.
- R5: A start address of 528 or more is reduced modulo 528 (for example, 1000 starts at 472), so `wr_addr` never exceeds 527.
- R6: A high level on `cs_n` ends the frame: a partly received byte is dropped with no write, serial clock edges while `cs_n` is high have no effect, and the next frame begins with a new command code.
- R7: Any command code other than the two above causes no write for the rest of that frame.
- R8: After reset, `wr_en`, `wr_buf`, `wr_addr` and `wr_data` are all 0, and `si` is taken only at rising edges of `sck`, whatever the idle level of `sck`.
- R9: A single frame keeps accepting bytes with no limit, including more bytes than the buffer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, asynchronous to clk |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data in, MSB first |
| wr_en | output | 1 | One-cycle buffer write strobe |
| wr_buf | output | 1 | Target buffer: 0 first, 1 second |
| wr_addr | output | 10 | Byte address within the buffer |
| wr_data | output | 8 | Byte to write |

## Verification
The assertions assume that `sck` and `cs_n` stay at each level for at least two `clk` cycles. This ensures that every serial edge is seen once and that writes are spaced apart. They also assume that `si` settles half a serial period before the rising edge that samples it. The bench holds each `sck` phase for four clock cycles and changes `si` only while `sck` is low. It drives every input on the falling clock edge, and it waits for several serial periods around each `cs_n` change, so the sequence of edges reaching the synchronisers is never ambiguous.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  typedef enum logic [2:0] {
    ST_CMD  = 3'd0,
    ST_SKIP = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_DROP = 3'd4
  } sbw_state_e;

  // Address following a, restarting at zero past the last byte.
  function automatic int unsigned sbw_next_addr(input int unsigned a,
                                                input int unsigned depth);
    return (a + 1 >= depth) ? 0 : a + 1;
  endfunction

  // Start address folded into the buffer range.
  function automatic int unsigned sbw_fold_addr(input int unsigned a,
                                                input int unsigned depth);
    return a % depth;
  endfunction

  // Returns {hit, select} for a received command code.
  function automatic logic [1:0] sbw_decode(input logic [7:0] code,
                                            input logic [7:0] code_a,
                                            input logic [7:0] code_b);
    if (code == code_a) return 2'b10;
    if (code == code_b) return 2'b11;
    return 2'b00;
  endfunction

endpackage

// File: rtl/sbw_sync.sv
module sbw_sync #(
  parameter int STAGES = 2,
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sbw_edge.sv
module sbw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic si_s,
  output logic bit_evt,
  output logic bit_val,
  output logic frame_clr
);
  logic sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  assign bit_evt   = sck_s & ~sck_prev & ~cs_n_s;
  assign bit_val   = si_s;
  assign frame_clr = cs_n_s;

  // R8: a serial rising edge lasts one clock cycle only
  assert_bit_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |=> !bit_evt);

  // R6: no bit is taken while the frame is closed
  assert_no_bit_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |-> !bit_evt);
endmodule

// File: rtl/sbw_shift.sv
module sbw_shift #(
  parameter int SH_W = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_evt,
  input  logic             bit_val,
  input  logic             restart,
  output logic [SH_W-1:0]  word_next,
  output logic [CNT_W-1:0] cnt
);
  logic [SH_W-1:0] sh_q;

  assign word_next = {sh_q[SH_W-2:0], bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      cnt  <= '0;
    end else if (clr) begin
      sh_q <= '0;
      cnt  <= '0;
    end else if (bit_evt) begin
      sh_q <= word_next;
      cnt  <= restart ? '0 : cnt + 1'b1;
    end
  end

  // R6: a closed frame leaves the bit counter at zero
  assert_cnt_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
  import sbw_pkg::*;
#(
  parameter int BUF_BYTES = 528,
  parameter int ADDR_W = 10,
  parameter int SKIP_BITS = 14,
  parameter int CODE_W = 8,
  parameter int DATA_W = 8,
  parameter int SH_W = 10,
  parameter int CNT_W = 4,
  parameter logic [7:0] CODE_A = 8'h84,
  parameter logic [7:0] CODE_B = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_evt,
  input  logic              frame_clr,
  input  logic [SH_W-1:0]   word_next,
  input  logic [CNT_W-1:0]  cnt,
  output logic              restart,
  output logic              wr_en,
  output logic              wr_buf,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int LAST_ADDR = BUF_BYTES - 1;

  sbw_state_e        st_q;
  logic              sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  field_last;
  logic              field_done;
  logic [1:0]        dec;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] step_addr;

  always_comb begin
    case (st_q)
      ST_CMD:  field_last = CNT_W'(CODE_W - 1);
      ST_SKIP: field_last = CNT_W'(SKIP_BITS - 1);
      ST_ADDR: field_last = CNT_W'(ADDR_W - 1);
      default: field_last = CNT_W'(DATA_W - 1);
    endcase
  end

  assign field_done = bit_evt & ~frame_clr & (st_q != ST_DROP) & (cnt == field_last);
  assign restart    = field_done;
  assign dec        = sbw_decode(word_next[CODE_W-1:0], CODE_A, CODE_B);
  assign start_addr = ADDR_W'(sbw_fold_addr(int'(word_next[ADDR_W-1:0]), BUF_BYTES));
  assign step_addr  = ADDR_W'(sbw_next_addr(int'(addr_q), BUF_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_CMD;
      sel_q   <= 1'b0;
      addr_q  <= '0;
      wr_en   <= 1'b0;
      wr_buf  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (frame_clr) begin
        st_q <= ST_CMD;
      end else if (field_done) begin
        case (st_q)
          ST_CMD: begin
            if (dec[1]) begin
              sel_q <= dec[0];
              st_q  <= ST_SKIP;
            end else begin
              st_q  <= ST_DROP;
            end
          end
          ST_SKIP: st_q <= ST_ADDR;
          ST_ADDR: begin
            addr_q <= start_addr;
            st_q   <= ST_DATA;
          end
          ST_DATA: begin
            wr_en   <= 1'b1;
            wr_buf  <= sel_q;
            wr_addr <= addr_q;
            wr_data <= word_next[DATA_W-1:0];
            addr_q  <= step_addr;
          end
          default: st_q <= ST_DROP;
        endcase
      end
    end
  end

  // R7: writes only come out of the data phase
  assert_write_from_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(st_q) == ST_DATA);

  // R3: each write strobe is a single cycle
  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R5: written addresses stay inside the buffer
  assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_addr) < BUF_BYTES);

  // R4: the byte after the last location goes to location zero
  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == LAST_ADDR) |-> addr_q == '0);

  // R4: otherwise the next location is one higher
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) != LAST_ADDR) |-> int'(addr_q) == int'(wr_addr) + 1);

  // R1: the buffer choice holds for the whole data phase
  assert_buf_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && !frame_clr) |=> $stable(sel_q));

  // R6: closing the frame returns to the command phase with no write
  assert_close_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |=> (st_q == ST_CMD && !wr_en));
endmodule

// File: rtl/sbuf_wr_front.sv
module sbuf_wr_front #(
  parameter int BUF_BYTES = 528,
  parameter int ADDR_W = 10,
  parameter int SKIP_BITS = 14,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] CODE_A = 8'h84,
  parameter logic [7:0] CODE_B = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              wr_en,
  output logic              wr_buf,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int CODE_W    = 8;
  localparam int DATA_W    = 8;
  localparam int SH_W      = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int FIELD_MAX = (SKIP_BITS > SH_W) ? SKIP_BITS : SH_W;
  localparam int CNT_W     = $clog2(FIELD_MAX + 1);

  logic [2:0]        raw_pins;
  logic [2:0]        sync_pins;
  logic              bit_evt;
  logic              bit_val;
  logic              frame_clr;
  logic              restart;
  logic [SH_W-1:0]   word_next;
  logic [CNT_W-1:0]  cnt;

  assign raw_pins = {cs_n, sck, si};

  sbw_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(sync_pins));

  sbw_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .sck_s(sync_pins[1]), .cs_n_s(sync_pins[2]), .si_s(sync_pins[0]),
    .bit_evt(bit_evt), .bit_val(bit_val), .frame_clr(frame_clr));

  sbw_shift #(.SH_W(SH_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(frame_clr), .bit_evt(bit_evt),
    .bit_val(bit_val), .restart(restart), .word_next(word_next), .cnt(cnt));

  sbw_ctrl #(
    .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .SKIP_BITS(SKIP_BITS),
    .CODE_W(CODE_W), .DATA_W(DATA_W), .SH_W(SH_W), .CNT_W(CNT_W),
    .CODE_A(CODE_A), .CODE_B(CODE_B)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .frame_clr(frame_clr),
    .word_next(word_next), .cnt(cnt), .restart(restart),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr), .wr_data(wr_data));

  // R8: nothing is written in the cycle after reset is released
  assert_quiet_after_reset_R8: assert property (@(posedge clk)
    $rose(rst_n) |-> !wr_en);
endmodule

// File: tb/test_sbuf_wr_front.sv
module test_sbuf_wr_front;
  localparam int HALF  = 4;
  localparam int DEPTH = 528;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic       wr_en;
  logic       wr_buf;
  logic [9:0] wr_addr;
  logic [7:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  int wr_count = 0;
  int cyc = 0;
  logic       log_buf  [0:1023];
  logic [9:0] log_addr [0:1023];
  logic [7:0] log_data [0:1023];

  always #2.5 clk = ~clk;

  sbuf_wr_front i_sbuf_wr_front (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr), .wr_data(wr_data));

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      log_buf[wr_count % 1024]  = wr_buf;
      log_addr[wr_count % 1024] = wr_addr;
      log_data[wr_count % 1024] = wr_data;
      wr_count++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pattern(input int i, input int seed);
    return 8'((i * 37 + seed) & 8'hFF);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0;
      si  = v[i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic open_frame(input bit mode3);
    sck = mode3;
    wait_clk(2 * HALF);
    cs_n = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic close_frame(input bit mode3);
    sck = mode3;
    wait_clk(2 * HALF);
    cs_n = 1'b1;
    wait_clk(5 * HALF);
  endtask

  // Full command frame with nbytes data bytes and extra trailing bits.
  task automatic frame(input logic [7:0] code, input logic [9:0] addr, input int nbytes,
                       input int seed, input int extra, input bit mode3);
    open_frame(mode3);
    send_bits(32'(code), 8);
    send_bits(32'h2A5B, 14);
    send_bits(32'(addr), 10);
    for (int i = 0; i < nbytes; i++) send_bits(32'(pattern(i, seed)), 8);
    if (extra > 0) send_bits(32'h0000_00B5, extra);
    close_frame(mode3);
  endtask

  task automatic verify(input string req, input int base, input int nexp, input bit ebuf,
                        input int start, input int seed);
    check(wr_count - base == nexp, req, wr_count - base, nexp);
    for (int i = 0; i < nexp && i < wr_count - base; i++) begin
      int k;
      k = (base + i) % 1024;
      check(log_buf[k] == ebuf, req, int'(log_buf[k]), int'(ebuf));
      check(int'(log_addr[k]) == (start % DEPTH + i) % DEPTH, req,
            int'(log_addr[k]), (start % DEPTH + i) % DEPTH);
      check(log_data[k] == pattern(i, seed), req, int'(log_data[k]), int'(pattern(i, seed)));
    end
  endtask

  task automatic t_reset;
    wait_clk(1);
    check(wr_en == 1'b0, "R8 reset wr_en", int'(wr_en), 0);
    check(wr_buf == 1'b0, "R8 reset wr_buf", int'(wr_buf), 0);
    check(wr_addr == 10'd0, "R8 reset wr_addr", int'(wr_addr), 0);
    check(wr_data == 8'd0, "R8 reset wr_data", int'(wr_data), 0);
  endtask

  task automatic t_first_buffer;
    int base = wr_count;
    frame(8'h84, 10'd5, 3, 11, 0, 1'b0);
    verify("R1 R2 R3 first buffer", base, 3, 1'b0, 5, 11);
  endtask

  task automatic t_second_buffer;
    int base = wr_count;
    frame(8'h87, 10'd100, 2, 200, 0, 1'b0);
    verify("R1 R3 second buffer", base, 2, 1'b1, 100, 200);
  endtask

  task automatic t_wrap;
    int base = wr_count;
    frame(8'h84, 10'd526, 4, 3, 0, 1'b0);
    verify("R4 wrap after 527", base, 4, 1'b0, 526, 3);
  endtask

  task automatic t_fold;
    int base = wr_count;
    frame(8'h87, 10'd1000, 2, 77, 0, 1'b0);
    verify("R5 start address folded to 472", base, 2, 1'b1, 1000, 77);
  endtask

  task automatic t_partial;
    int base = wr_count;
    frame(8'h84, 10'd10, 1, 5, 5, 1'b0);
    verify("R6 partial byte dropped", base, 1, 1'b0, 10, 5);
    base = wr_count;
    frame(8'h87, 10'd3, 1, 9, 0, 1'b0);
    verify("R6 next frame restarts with command", base, 1, 1'b1, 3, 9);
  endtask

  task automatic t_bad_code;
    int base = wr_count;
    frame(8'h85, 10'd0, 3, 1, 0, 1'b0);
    check(wr_count == base, "R7 unknown code 0x85 writes", wr_count - base, 0);
    base = wr_count;
    frame(8'h53, 10'd7, 2, 1, 0, 1'b1);
    check(wr_count == base, "R7 unknown code 0x53 writes", wr_count - base, 0);
  endtask

  task automatic t_mode3;
    int base = wr_count;
    frame(8'h84, 10'd20, 2, 90, 0, 1'b1);
    verify("R8 idle-high clock", base, 2, 1'b0, 20, 90);
  endtask

  task automatic t_idle_toggle;
    int base = wr_count;
    for (int i = 0; i < 40; i++) begin
      si  = i[0];
      sck = ~sck;
      wait_clk(HALF);
    end
    sck = 1'b0;
    wait_clk(4 * HALF);
    check(wr_count == base, "R6 clocks with cs_n high", wr_count - base, 0);
    frame(8'h87, 10'd527, 2, 44, 0, 1'b0);
    verify("R6 R4 frame after idle clocks", base, 2, 1'b1, 527, 44);
  endtask

  task automatic t_long;
    int base = wr_count;
    frame(8'h84, 10'd0, 530, 123, 0, 1'b0);
    verify("R9 stream past buffer size", base, 530, 1'b0, 0, 123);
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    t_reset();
    t_first_buffer();
    t_second_buffer();
    t_wrap();
    t_fold();
    t_partial();
    t_bad_code();
    t_mode3();
    t_idle_toggle();
    t_long();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule